// File: doc/BRIEF.md
# Standby Rail and Forced-Shutdown Sequencer

This block owns two board controls of a platform power controller: the enable of the standby rail group and the active-low resume-reset line. On request it brings the platform from fully off (OFF, the G3 level) to standby (STANDBY, the S5 level). It drives the rail enable, waits for every core power-good input, and then gives the suspend-sleep signal a bounded window to deassert. Once in standby it watches that signal and starts shutdown when the signal is asserted again.

The shutdown path (SHUTDOWN) runs in a fixed order. Resume-reset goes low first. The rail enable drops one cycle later. The block then checks the deep-well power-OK and resume-reset power-good inputs on each millisecond tick. It returns to OFF as soon as either input falls, or after a fixed number of ticks. In the second case it raises a sticky timeout flag. A forced-shutdown request can interrupt the sequence at any point, and it wins over a power-up request in the same cycle.

States and transitions: OFF(0) goes to RAMP_UP(1) on an accepted power-up request. RAMP_UP goes to STANDBY(2) when suspend-sleep deasserts after core power-good. RAMP_UP goes to SHUTDOWN(3) on the suspend-sleep window timeout or on a force. STANDBY goes to SHUTDOWN on suspend-sleep assertion or on a force. SHUTDOWN goes to OFF when an input falls or when the off window expires. OFF goes to SHUTDOWN on a force.

Top module: `stby_rail_ctrl`

## Requirements
- R1: In OFF, a power-up request without a force moves the state to RAMP_UP (code 1) and sets rail_en high at the same clock edge.
- R2: In RAMP_UP the block waits with no time limit until every bit of core_pg is high; no tick is counted while any bit is low.
- R3: After all core power-good bits are seen high, sus_deasserted high moves the state to STANDBY (code 2) at the next edge. If SUS_WAIT_MS ticks pass with it low, the state moves to SHUTDOWN (code 3) at the edge that samples the last tick.
- R4: In STANDBY, sus_deasserted low moves the state to SHUTDOWN at the next edge.
- R5: On entry to SHUTDOWN, rsm_rst_n is low from the entry edge, and rail_en falls exactly one edge later.
- R6: In SHUTDOWN after the rails are off, a tick sampled while dw_pwr_ok or rsm_pg is low returns the state to OFF and leaves off_timeout unchanged.
- R7: If OFF_WAIT_MS ticks pass in SHUTDOWN with both dw_pwr_ok and rsm_pg high, the state returns to OFF and off_timeout goes high at the same edge.
- R8: rsm_rst_n is high only after a clock edge at which the block was in STANDBY, stays in STANDBY and sees rsm_pg high. Otherwise it is low, including during reset.
- R9: force_off moves OFF, RAMP_UP or STANDBY to SHUTDOWN at the next edge, even if a power-up request is present in the same cycle. In SHUTDOWN, force_off has no effect.
- R10: pwr_state uses the codes OFF=0, RAMP_UP=1, STANDBY=2, SHUTDOWN=3. After reset it reads 0, with rail_en and off_timeout low.
- R11: off_timeout is cleared only when a power-up request is accepted in OFF. A power-up request in any other state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| pwr_up_req | input | 1 | Request to bring the platform to standby |
| force_off | input | 1 | Request for a forced shutdown |
| core_pg | input | NUM_CORE_PG | Core rail power-good inputs, all must be high |
| sus_deasserted | input | 1 | High while the suspend-sleep signal is deasserted |
| dw_pwr_ok | input | 1 | Deep-well power-OK input |
| rsm_pg | input | 1 | Resume-reset power-good input |
| rail_en | output | 1 | Standby rail group enable |
| rsm_rst_n | output | 1 | Resume reset, active low |
| pwr_state | output | 2 | Current state code |
| off_timeout | output | 1 | Sticky flag: shutdown inputs failed to fall in time |

## Verification
A wrong state register shows on pwr_state at the next edge. It also shows on rail_en or rsm_rst_n within one or two cycles, because both are derived from state transitions. A miscounted millisecond window shifts the RAMP_UP-to-SHUTDOWN or SHUTDOWN-to-OFF edge by a multiple of the tick period, and the flag appears or goes missing. The bench therefore compares every output on every cycle against a behavioural model, so a single-cycle shift is caught where it happens.

// File: rtl/stby_rail_pkg.sv
package stby_rail_pkg;

    typedef enum logic [1:0] {
        ST_OFF      = 2'd0,
        ST_RAMP_UP  = 2'd1,
        ST_STANDBY  = 2'd2,
        ST_SHUTDOWN = 2'd3
    } pwr_state_e;

endpackage

// File: rtl/ms_window_cnt.sv
module ms_window_cnt #(
    parameter int LIMIT = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic last
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign last = (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (adv && !last) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT - 1)); // R7

endmodule

// File: rtl/stby_seq_fsm.sv
module stby_seq_fsm
    import stby_rail_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       pwr_up_req,
    input  logic       force_off,
    input  logic       core_all_pg,
    input  logic       sus_deasserted,
    input  logic       dw_pwr_ok,
    input  logic       rsm_pg,
    input  logic       sus_last,
    input  logic       off_last,
    output logic       sus_clr,
    output logic       sus_adv,
    output logic       off_clr,
    output logic       off_adv,
    output logic       rail_en,
    output logic       rsm_rst_n,
    output logic [1:0] state,
    output logic       off_timeout
);
    pwr_state_e state_q, state_d;
    logic       sub_q, sub_d;
    logic       accept, to_set;
    logic       rail_q, rsm_q, to_q;

    // Window counters run only in the waiting phase of their state
    assign sus_clr = !(state_q == ST_RAMP_UP && sub_q);
    assign sus_adv = (state_q == ST_RAMP_UP) && sub_q && tick && !sus_deasserted;
    assign off_clr = !(state_q == ST_SHUTDOWN && sub_q);
    assign off_adv = (state_q == ST_SHUTDOWN) && sub_q && tick && dw_pwr_ok && rsm_pg;

    always_comb begin
        state_d = state_q;
        sub_d   = sub_q;
        accept  = 1'b0;
        to_set  = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (force_off) begin
                    state_d = ST_SHUTDOWN;
                    sub_d   = 1'b0;
                end else if (pwr_up_req) begin
                    state_d = ST_RAMP_UP;
                    sub_d   = 1'b0;
                    accept  = 1'b1;
                end
            end
            ST_RAMP_UP: begin
                if (force_off) begin
                    state_d = ST_SHUTDOWN;
                    sub_d   = 1'b0;
                end else if (!sub_q) begin
                    if (core_all_pg) begin
                        sub_d = 1'b1;
                    end
                end else if (sus_deasserted) begin
                    state_d = ST_STANDBY;
                    sub_d   = 1'b0;
                end else if (tick && sus_last) begin
                    state_d = ST_SHUTDOWN;
                    sub_d   = 1'b0;
                end
            end
            ST_STANDBY: begin
                if (force_off || !sus_deasserted) begin
                    state_d = ST_SHUTDOWN;
                    sub_d   = 1'b0;
                end
            end
            ST_SHUTDOWN: begin
                if (!sub_q) begin
                    sub_d = 1'b1;
                end else if (tick) begin
                    if (!dw_pwr_ok || !rsm_pg) begin
                        state_d = ST_OFF;
                        sub_d   = 1'b0;
                    end else if (off_last) begin
                        state_d = ST_OFF;
                        sub_d   = 1'b0;
                        to_set  = 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_OFF;
                sub_d   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            sub_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            sub_q   <= sub_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rail_q <= 1'b0;
            rsm_q  <= 1'b0;
            to_q   <= 1'b0;
        end else begin
            if (accept) begin
                rail_q <= 1'b1;
            end else if (state_q == ST_SHUTDOWN && !sub_q) begin
                rail_q <= 1'b0;
            end
            if (accept) begin
                to_q <= 1'b0;
            end else if (to_set) begin
                to_q <= 1'b1;
            end
            rsm_q <= (state_q == ST_STANDBY) && (state_d == ST_STANDBY) && rsm_pg;
        end
    end

    assign rail_en     = rail_q;
    assign rsm_rst_n   = rsm_q;
    assign state       = state_q;
    assign off_timeout = to_q;

    AST_REQ_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && pwr_up_req && !force_off) |=> (state_q == ST_RAMP_UP && rail_q && !to_q)); // R1

    AST_S5_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STANDBY && !sus_deasserted) |=> (state_q == ST_SHUTDOWN)); // R4

    AST_RAIL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rail_q) |-> (!rsm_q && $past(!rsm_q))); // R5

    AST_TIMEOUT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(to_q) |-> (state_q == ST_OFF && $past(state_q) == ST_SHUTDOWN)); // R7

    AST_RSM_ONLY_S5: assert property (@(posedge clk) disable iff (!rst_n)
        rsm_q |-> (state_q == ST_STANDBY)); // R8

    AST_FORCE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (force_off && state_q != ST_SHUTDOWN) |=> (state_q == ST_SHUTDOWN)); // R9

endmodule

// File: rtl/stby_rail_ctrl.sv
module stby_rail_ctrl #(
    parameter int NUM_CORE_PG = 3,
    parameter int SUS_WAIT_MS = 250,
    parameter int OFF_WAIT_MS = 50
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_1ms,
    input  logic                   pwr_up_req,
    input  logic                   force_off,
    input  logic [NUM_CORE_PG-1:0] core_pg,
    input  logic                   sus_deasserted,
    input  logic                   dw_pwr_ok,
    input  logic                   rsm_pg,
    output logic                   rail_en,
    output logic                   rsm_rst_n,
    output logic [1:0]             pwr_state,
    output logic                   off_timeout
);
    logic core_all_pg;
    logic sus_clr, sus_adv, sus_last;
    logic off_clr, off_adv, off_last;

    assign core_all_pg = &core_pg;

    ms_window_cnt #(.LIMIT(SUS_WAIT_MS)) u_sus_win (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sus_clr),
        .adv   (sus_adv),
        .last  (sus_last)
    );

    ms_window_cnt #(.LIMIT(OFF_WAIT_MS)) u_off_win (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (off_clr),
        .adv   (off_adv),
        .last  (off_last)
    );

    stby_seq_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick           (tick_1ms),
        .pwr_up_req     (pwr_up_req),
        .force_off      (force_off),
        .core_all_pg    (core_all_pg),
        .sus_deasserted (sus_deasserted),
        .dw_pwr_ok      (dw_pwr_ok),
        .rsm_pg         (rsm_pg),
        .sus_last       (sus_last),
        .off_last       (off_last),
        .sus_clr        (sus_clr),
        .sus_adv        (sus_adv),
        .off_clr        (off_clr),
        .off_adv        (off_adv),
        .rail_en        (rail_en),
        .rsm_rst_n      (rsm_rst_n),
        .state          (pwr_state),
        .off_timeout    (off_timeout)
    );

endmodule

// File: tb/stby_rail_ctrl_bench.sv
module stby_rail_ctrl_bench;
    localparam int NPG    = 3;
    localparam int SUS_MS = 250;
    localparam int OFF_MS = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_1ms = 1'b0;
    logic pwr_up_req = 1'b0;
    logic force_off = 1'b0;
    logic [NPG-1:0] core_pg = '0;
    logic sus_deasserted = 1'b0;
    logic dw_pwr_ok = 1'b0;
    logic rsm_pg = 1'b0;
    logic rail_en, rsm_rst_n, off_timeout;
    logic [1:0] pwr_state;

    int vecs = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    // behavioural reference
    int m_state = 0, m_phase = 0, m_cnt = 0, m_rail = 0, m_rsm = 0, m_to = 0;
    int ns, np, nc, nrail, nto;

    always #4 clk = ~clk;

    stby_rail_ctrl #(.NUM_CORE_PG(NPG), .SUS_WAIT_MS(SUS_MS), .OFF_WAIT_MS(OFF_MS)) u_stby_rail_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_1ms       (tick_1ms),
        .pwr_up_req     (pwr_up_req),
        .force_off      (force_off),
        .core_pg        (core_pg),
        .sus_deasserted (sus_deasserted),
        .dw_pwr_ok      (dw_pwr_ok),
        .rsm_pg         (rsm_pg),
        .rail_en        (rail_en),
        .rsm_rst_n      (rsm_rst_n),
        .pwr_state      (pwr_state),
        .off_timeout    (off_timeout)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_phase = 0; m_cnt = 0; m_rail = 0; m_rsm = 0; m_to = 0;
        end else begin
            ns = m_state; np = m_phase; nc = m_cnt; nrail = m_rail; nto = m_to;
            case (m_state)
                0: if (force_off) begin ns = 3; np = 0; end
                   else if (pwr_up_req) begin ns = 1; np = 0; nrail = 1; nto = 0; end
                1: if (force_off) begin ns = 3; np = 0; end
                   else if (m_phase == 0) begin
                       if (core_pg == {NPG{1'b1}}) begin np = 1; nc = 0; end
                   end else if (sus_deasserted) begin ns = 2; np = 0; end
                   else if (tick_1ms) begin
                       nc = m_cnt + 1;
                       if (nc == SUS_MS) begin ns = 3; np = 0; end
                   end
                2: if (force_off || !sus_deasserted) begin ns = 3; np = 0; end
                default: if (m_phase == 0) begin nrail = 0; np = 1; nc = 0; end
                   else if (tick_1ms) begin
                       if (!dw_pwr_ok || !rsm_pg) begin ns = 0; np = 0; end
                       else begin
                           nc = m_cnt + 1;
                           if (nc == OFF_MS) begin ns = 0; np = 0; nto = 1; end
                       end
                   end
            endcase
            m_rsm = (m_state == 2 && ns == 2 && rsm_pg) ? 1 : 0;
            m_state = ns; m_phase = np; m_cnt = nc; m_rail = nrail; m_to = nto;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // per-cycle comparison, tick generation and watchdog
    always @(negedge clk) begin
        if (!done) begin
            cyc++;
            if (rst_n) begin
                chk("R10 state", int'(pwr_state), m_state);
                chk("R1 rail_en", int'(rail_en), m_rail);
                chk("R8 rsm_rst_n", int'(rsm_rst_n), m_rsm);
                chk("R7 off_timeout", int'(off_timeout), m_to);
            end
            tick_1ms = ((cyc % 4) == 3);
            if (cyc > 150000) begin
                fails++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
                done = 1'b1;
                $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
                $finish;
            end
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_state(input string tag, input int s, input int limit);
        int k;
        k = 0;
        while (int'(pwr_state) != s && k < limit) begin
            @(negedge clk);
            k++;
        end
        chk(tag, int'(pwr_state), s);
    endtask

    task automatic pulse_req(input bit rq, input bit fo);
        pwr_up_req = rq;
        force_off  = fo;
        @(negedge clk);
        pwr_up_req = 1'b0;
        force_off  = 1'b0;
    endtask

    initial begin
        cycles(3);
        chk("R10 reset state", int'(pwr_state), 0);
        chk("R10 reset rail_en", int'(rail_en), 0);
        chk("R8 reset rsm_rst_n", int'(rsm_rst_n), 0);
        chk("R10 reset off_timeout", int'(off_timeout), 0);
        rst_n = 1'b1;
        cycles(2);

        // normal power-up
        pulse_req(1'b1, 1'b0);
        chk("R1 ramp state", int'(pwr_state), 1);
        chk("R1 rail_en high", int'(rail_en), 1);
        core_pg = 3'b011;
        cycles(1200);
        chk("R2 partial pg keeps waiting", int'(pwr_state), 1);
        core_pg = 3'b111;
        cycles(40);
        chk("R3 still in ramp", int'(pwr_state), 1);
        sus_deasserted = 1'b1; rsm_pg = 1'b1; dw_pwr_ok = 1'b1;
        cycles(1);
        chk("R3 standby reached", int'(pwr_state), 2);
        chk("R8 rsm still low on entry", int'(rsm_rst_n), 0);
        cycles(1);
        chk("R8 rsm released", int'(rsm_rst_n), 1);

        // request ignored outside OFF
        pulse_req(1'b1, 1'b0);
        chk("R11 request ignored in standby", int'(pwr_state), 2);

        // suspend asserted, ordered shutdown, input falls
        sus_deasserted = 1'b0;
        cycles(1);
        chk("R4 shutdown entered", int'(pwr_state), 3);
        chk("R5 rsm low first", int'(rsm_rst_n), 0);
        chk("R5 rail still on", int'(rail_en), 1);
        cycles(1);
        chk("R5 rail off next", int'(rail_en), 0);
        dw_pwr_ok = 1'b0;
        wait_state("R6 back to off", 0, 20);
        chk("R6 no flag", int'(off_timeout), 0);

        // suspend window timeout, then off window timeout
        dw_pwr_ok = 1'b1;
        pulse_req(1'b1, 1'b0);
        wait_state("R3 sus timeout to shutdown", 3, 1100);
        wait_state("R7 off window expiry", 0, 260);
        chk("R7 flag raised", int'(off_timeout), 1);

        // force wins over request; flag stays until accept
        pulse_req(1'b1, 1'b1);
        chk("R9 force beats request", int'(pwr_state), 3);
        chk("R11 flag kept", int'(off_timeout), 1);
        cycles(3);
        pulse_req(1'b0, 1'b1);
        chk("R9 force ignored in shutdown", int'(pwr_state), 3);
        rsm_pg = 1'b0;
        wait_state("R6 rsm_pg fall exits", 0, 20);
        chk("R11 flag survives non-timeout exit", int'(off_timeout), 1);
        pulse_req(1'b1, 1'b0);
        chk("R11 flag cleared on accept", int'(off_timeout), 0);
        cycles(5);
        pulse_req(1'b0, 1'b1);
        chk("R9 force interrupts ramp", int'(pwr_state), 3);
        wait_state("R6 exit after force", 0, 20);
        cycles(4);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

endmodule